// File: doc/BRIEF.md
# Serial Bus Interrupt Flag Controller

This block holds the single interrupt request flag of a serial bus interface. The interface can run as a two-wire bus master, as a two-wire bus slave, or as a clocked synchronous serial port. A separate bit-level engine produces one-cycle event pulses: start and stop seen on the bus, a start issued by this side, falling clock edge 8, rising clock edge 9, arbitration lost, slave address received, own-address match, general-call match, a sampled acknowledge bit, transmit-empty and receive-full. The controller decides, per mode, which of these pulses raise the flag.

Two small pieces of state set the rules. A pending-start bit remembers that this side issued a start condition. An arbitration-lost bit remembers that this side lost the bus. A slave address window opens on an address match or a general call and closes on the next start or stop, and end-of-byte events count in slave mode only while the window is open. Software reaches the flag through a one-bit register port. A read that returns 1 arms the flag. Only a write of 0 while armed clears it. The interrupt output is the flag gated by an enable input.

Top module: `sbi_irq_flag_ctrl`

## Requirements
- R1: After reset the flag, the interrupt output and the NACK status are 0, and no clear is armed.
- R2: In master mode (mode code 2'b00) a bus start condition sets the flag only after this side has issued a start; a start seen without one leaves the flag at 0.
- R3: In master mode with wait disabled, rising clock edge 9 sets the flag and falling edge 8 does not. With wait enabled, falling edge 8 sets it and rising edge 9 does not.
- R4: In master mode, a received slave address sets the flag only after arbitration was lost; a stop condition forgets the loss.
- R5: In master or slave mode with acknowledge checking on, a sampled acknowledge of 1 sets the flag and the NACK status; a sampled acknowledge of 0 clears the NACK status; with checking off the acknowledge has no effect.
- R6: In slave mode (mode code 2'b01) an own-address match or a general call sets the flag and opens the address window.
- R7: In slave mode, transmit-empty or receive-full sets the flag only while the address window is open; a start or stop closes the window.
- R8: In slave mode a stop condition sets the flag.
- R9: In synchronous serial mode (mode code 2'b10) transmit-empty, receive-full and start detection set the flag; no other event does. Mode code 2'b11 sets nothing.
- R10: A write of 0 clears the flag only if the last flag access before it was a read that returned 1; any write disarms; writing 1 never sets the flag.
- R11: When a set event and a valid clearing write fall in the same cycle, the flag ends at 1.
- R12: The interrupt output is 1 exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 master, 01 slave, 10 synchronous serial, 11 idle |
| wait_en_i | input | 1 | Master wait between data and acknowledge |
| ack_chk_en_i | input | 1 | Acknowledge checking enable |
| irq_en_i | input | 1 | Interrupt enable |
| start_issued_i | input | 1 | Pulse: this side issued a start |
| start_det_i | input | 1 | Pulse: start condition seen on the bus |
| stop_det_i | input | 1 | Pulse: stop condition seen on the bus |
| clk8_fall_i | input | 1 | Pulse: falling edge of clock 8 |
| clk9_rise_i | input | 1 | Pulse: rising edge of clock 9 |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| addr_rcvd_i | input | 1 | Pulse: slave address byte received |
| addr_match_i | input | 1 | Pulse: own address matched |
| gcall_det_i | input | 1 | Pulse: general-call address detected |
| ack_valid_i | input | 1 | Pulse: acknowledge bit sampled |
| ack_bit_i | input | 1 | Sampled acknowledge value |
| tx_empty_i | input | 1 | Pulse: transmit buffer became empty |
| rx_full_i | input | 1 | Pulse: receive buffer became full |
| rd_en_i | input | 1 | Register read strobe for the flag |
| wr_en_i | input | 1 | Register write strobe for the flag |
| wr_data_i | input | 1 | Register write value |
| rd_data_o | output | 1 | Current flag value, valid during a read |
| flag_o | output | 1 | Interrupt request flag |
| nack_o | output | 1 | Latched received-NACK status |
| irq_o | output | 1 | Flag gated by the enable |

## Verification
Every event, write and state change is registered once, so the flag, the NACK status and the window are due on the first rising edge after the cycle in which a pulse or strobe is held. The bench drives each pulse for one cycle from a falling edge and checks the outputs at the next falling edge. Read data and the interrupt output are combinational and are checked within the same cycle. The single-event sweep resets before each case, so no state left over from one case reaches the next.

// File: rtl/sbi_irq_pkg.sv
package sbi_irq_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_MASTER = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_SYNC   = 2'b10,
    MODE_IDLE   = 2'b11
  } sbi_mode_e;

  // Edge that ends a master byte depends on whether a wait is inserted.
  function automatic logic master_byte_end(input logic wait_en,
                                           input logic c8_fall,
                                           input logic c9_rise);
    return wait_en ? c8_fall : c9_rise;
  endfunction

  // A data transfer ends when either buffer changes state.
  function automatic logic data_end(input logic tx_empty, input logic rx_full);
    return tx_empty | rx_full;
  endfunction

  // A received NACK counts only while acknowledge checking is on.
  function automatic logic nack_seen(input logic chk_en, input logic valid,
                                     input logic ack_bit);
    return chk_en & valid & ack_bit;
  endfunction
endpackage

// File: rtl/sbi_irq_master_track.sv
module sbi_irq_master_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_issued_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  output logic start_pend_o,
  output logic arb_lost_o
);
  logic start_pend_q, arb_lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend_q <= 1'b0;
    end else if (start_issued_i) begin
      start_pend_q <= 1'b1;
    end else if (start_det_i || stop_det_i) begin
      start_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost_q <= 1'b0;
    end else if (arb_lost_i) begin
      arb_lost_q <= 1'b1;
    end else if (stop_det_i || start_issued_i) begin
      arb_lost_q <= 1'b0;
    end
  end

  assign start_pend_o = start_pend_q;
  assign arb_lost_o   = arb_lost_q;

  p_pend_follows_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_issued_i |=> start_pend_o);
  p_stop_forgets_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det_i && !arb_lost_i) |=> !arb_lost_o);
endmodule

// File: rtl/sbi_irq_addr_window.sv
module sbi_irq_addr_window (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode_i,
  input  logic addr_match_i,
  input  logic gcall_det_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  output logic win_open_o
);
  logic win_q;
  logic open_ev, close_ev;

  assign open_ev  = slave_mode_i & (addr_match_i | gcall_det_i);
  assign close_ev = start_det_i | stop_det_i | ~slave_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else if (open_ev) begin
      win_q <= 1'b1;
    end else if (close_ev) begin
      win_q <= 1'b0;
    end
  end

  assign win_open_o = win_q;

  p_window_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i && (addr_match_i || gcall_det_i)) |=> win_open_o);
  p_window_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det_i || stop_det_i) && !addr_match_i && !gcall_det_i) |=> !win_open_o);
endmodule

// File: rtl/sbi_irq_event_sel.sv
module sbi_irq_event_sel
  import sbi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wait_en_i,
  input  logic              ack_chk_en_i,
  input  logic              start_pend_i,
  input  logic              arb_lost_i,
  input  logic              win_open_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              clk8_fall_i,
  input  logic              clk9_rise_i,
  input  logic              addr_rcvd_i,
  input  logic              addr_match_i,
  input  logic              gcall_det_i,
  input  logic              ack_valid_i,
  input  logic              ack_bit_i,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  output logic              set_ev_o,
  output logic              nack_o
);
  logic is_master, is_slave, is_sync;
  logic ev_m_start, ev_m_byte, ev_m_arb_addr, ev_nack;
  logic ev_s_addr, ev_s_data, ev_s_stop;
  logic ev_y_data, ev_y_start;
  logic nack_q;

  assign is_master = (mode_i == MODE_MASTER);
  assign is_slave  = (mode_i == MODE_SLAVE);
  assign is_sync   = (mode_i == MODE_SYNC);

  assign ev_m_start    = is_master & start_det_i & start_pend_i;
  assign ev_m_byte     = is_master & master_byte_end(wait_en_i, clk8_fall_i, clk9_rise_i);
  assign ev_m_arb_addr = is_master & arb_lost_i & addr_rcvd_i;
  assign ev_nack       = (is_master | is_slave) & nack_seen(ack_chk_en_i, ack_valid_i, ack_bit_i);
  assign ev_s_addr     = is_slave & (addr_match_i | gcall_det_i);
  assign ev_s_data     = is_slave & win_open_i & data_end(tx_empty_i, rx_full_i);
  assign ev_s_stop     = is_slave & stop_det_i;
  assign ev_y_data     = is_sync & data_end(tx_empty_i, rx_full_i);
  assign ev_y_start    = is_sync & start_det_i;

  assign set_ev_o = ev_m_start | ev_m_byte | ev_m_arb_addr | ev_nack |
                    ev_s_addr | ev_s_data | ev_s_stop | ev_y_data | ev_y_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_q <= 1'b0;
    end else if (ev_nack) begin
      nack_q <= 1'b1;
    end else if ((is_master | is_slave) & ack_chk_en_i & ack_valid_i & ~ack_bit_i) begin
      nack_q <= 1'b0;
    end
  end

  assign nack_o = nack_q;

  p_nack_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> nack_o);
  p_sync_only_data_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sync && !start_det_i && !tx_empty_i && !rx_full_i) |-> !set_ev_o);
  p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_IDLE) |-> !set_ev_o);
  p_slave_data_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && !win_open_i && !stop_det_i && !addr_match_i && !gcall_det_i &&
     !(ack_chk_en_i && ack_valid_i && ack_bit_i)) |-> !set_ev_o);
endmodule

// File: rtl/sbi_irq_flag_reg.sv
module sbi_irq_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev_i,
  input  logic rd_en_i,
  input  logic wr_en_i,
  input  logic wr_data_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q;
  logic clr_ok;

  assign clr_ok = wr_en_i & ~wr_data_i & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_ev_i) begin
      flag_q <= 1'b1;
    end else if (clr_ok) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_en_i) begin
      armed_q <= 1'b0;
    end else if (rd_en_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev_i |=> flag_o);
  p_no_set_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_ev_i) |=> !flag_o);
  p_clear_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !armed_o) |=> flag_o);
  p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> !armed_o);
endmodule

// File: rtl/sbi_irq_flag_ctrl.sv
module sbi_irq_flag_ctrl
  import sbi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wait_en_i,
  input  logic              ack_chk_en_i,
  input  logic              irq_en_i,
  input  logic              start_issued_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              clk8_fall_i,
  input  logic              clk9_rise_i,
  input  logic              arb_lost_i,
  input  logic              addr_rcvd_i,
  input  logic              addr_match_i,
  input  logic              gcall_det_i,
  input  logic              ack_valid_i,
  input  logic              ack_bit_i,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              wr_data_i,
  output logic              rd_data_o,
  output logic              flag_o,
  output logic              nack_o,
  output logic              irq_o
);
  logic start_pend, arb_lost, win_open, set_ev, flag, armed;

  sbi_irq_master_track u_mtrack (
    .clk(clk), .rst_n(rst_n),
    .start_issued_i(start_issued_i), .start_det_i(start_det_i),
    .stop_det_i(stop_det_i), .arb_lost_i(arb_lost_i),
    .start_pend_o(start_pend), .arb_lost_o(arb_lost)
  );

  sbi_irq_addr_window u_window (
    .clk(clk), .rst_n(rst_n),
    .slave_mode_i(mode_i == MODE_SLAVE),
    .addr_match_i(addr_match_i), .gcall_det_i(gcall_det_i),
    .start_det_i(start_det_i), .stop_det_i(stop_det_i),
    .win_open_o(win_open)
  );

  sbi_irq_event_sel u_sel (
    .clk(clk), .rst_n(rst_n),
    .mode_i(mode_i), .wait_en_i(wait_en_i), .ack_chk_en_i(ack_chk_en_i),
    .start_pend_i(start_pend), .arb_lost_i(arb_lost), .win_open_i(win_open),
    .start_det_i(start_det_i), .stop_det_i(stop_det_i),
    .clk8_fall_i(clk8_fall_i), .clk9_rise_i(clk9_rise_i),
    .addr_rcvd_i(addr_rcvd_i), .addr_match_i(addr_match_i),
    .gcall_det_i(gcall_det_i), .ack_valid_i(ack_valid_i),
    .ack_bit_i(ack_bit_i), .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i),
    .set_ev_o(set_ev), .nack_o(nack_o)
  );

  sbi_irq_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n),
    .set_ev_i(set_ev), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .flag_o(flag), .armed_o(armed)
  );

  assign flag_o    = flag;
  assign rd_data_o = flag;
  assign irq_o     = flag & irq_en_i;

  p_master_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MASTER && start_det_i && start_pend) |=> flag_o);
  p_arb_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MASTER && arb_lost && addr_rcvd_i) |=> flag_o);
  p_slave_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SLAVE && stop_det_i) |=> flag_o);
  p_irq_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/sbi_irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module sbi_irq_flag_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wait_en = 0, ack_chk_en = 0, irq_en = 0;
  logic start_issued = 0, start_det = 0, stop_det = 0, clk8_fall = 0, clk9_rise = 0;
  logic arb_lost = 0, addr_rcvd = 0, addr_match = 0, gcall_det = 0;
  logic ack_valid = 0, ack_bit = 0, tx_empty = 0, rx_full = 0;
  logic rd_en = 0, wr_en = 0, wr_data = 0;
  logic rd_data, flag, nack, irq;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sbi_irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wait_en_i(wait_en),
    .ack_chk_en_i(ack_chk_en), .irq_en_i(irq_en),
    .start_issued_i(start_issued), .start_det_i(start_det), .stop_det_i(stop_det),
    .clk8_fall_i(clk8_fall), .clk9_rise_i(clk9_rise), .arb_lost_i(arb_lost),
    .addr_rcvd_i(addr_rcvd), .addr_match_i(addr_match), .gcall_det_i(gcall_det),
    .ack_valid_i(ack_valid), .ack_bit_i(ack_bit), .tx_empty_i(tx_empty),
    .rx_full_i(rx_full), .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .flag_o(flag), .nack_o(nack), .irq_o(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one event for one cycle; outputs are checked at the following negedge.
  task automatic pulse(input int ev);
    @(negedge clk);
    case (ev)
      0: start_det = 1;  1: stop_det = 1;   2: clk8_fall = 1;  3: clk9_rise = 1;
      4: addr_rcvd = 1;  5: addr_match = 1; 6: gcall_det = 1;
      7: begin ack_valid = 1; ack_bit = 1; end
      8: tx_empty = 1;   9: rx_full = 1;    10: start_issued = 1; 11: arb_lost = 1;
      12: begin ack_valid = 1; ack_bit = 0; end
      default: ;
    endcase
    @(negedge clk);
    {start_det, stop_det, clk8_fall, clk9_rise, addr_rcvd, addr_match, gcall_det} = '0;
    {ack_valid, ack_bit, tx_empty, rx_full, start_issued, arb_lost} = '0;
  endtask

  task automatic read_flag(output logic v);
    @(negedge clk);
    rd_en = 1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic write_flag(input logic d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic clear_flag();
    logic v;
    read_flag(v);
    write_flag(1'b0);
  endtask

  // Expected flag after one isolated event from reset, wait off, checking on.
  function automatic logic sweep_exp(input int m, input int ev);
    case (m)
      0: return (ev == 3) || (ev == 7);
      1: return (ev == 1) || (ev == 5) || (ev == 6) || (ev == 7);
      2: return (ev == 0) || (ev == 8) || (ev == 9);
      default: return 1'b0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic v;
    do_reset();
    // R1 reset state
    check("R1 flag", flag, 1'b0);
    check("R1 nack", nack, 1'b0);
    irq_en = 1;
    check("R1 irq", irq, 1'b0);
    irq_en = 0;

    // Sweep: every mode against every isolated event (R2 R4 R5 R6 R7 R8 R9 R3)
    ack_chk_en = 1;
    for (int m = 0; m < 4; m++) begin
      for (int ev = 0; ev < 10; ev++) begin
        do_reset();
        mode = m[1:0];
        pulse(ev);
        check($sformatf("R9 sweep mode%0d ev%0d", m, ev), flag, sweep_exp(m, ev));
        if (ev == 7)
          check($sformatf("R5 nack mode%0d", m), nack, (m < 2));
      end
    end

    // R2 master start after issuing one
    do_reset(); mode = 2'b00;
    pulse(10); check("R2 issue alone", flag, 1'b0);
    pulse(0);  check("R2 start after issue", flag, 1'b1);

    // R3 wait enabled selects edge 8
    do_reset(); wait_en = 1;
    pulse(3); check("R3 wait edge9 ignored", flag, 1'b0);
    pulse(2); check("R3 wait edge8", flag, 1'b1);
    wait_en = 0;
    do_reset();
    pulse(2); check("R3 nowait edge8 ignored", flag, 1'b0);

    // R4 arbitration loss then address
    do_reset();
    pulse(11); pulse(4); check("R4 addr after loss", flag, 1'b1);
    do_reset();
    pulse(11); pulse(1); pulse(4); check("R4 stop forgets loss", flag, 1'b0);

    // R5 ack handling
    do_reset(); ack_chk_en = 0;
    pulse(7); check("R5 chk off flag", flag, 1'b0);
    check("R5 chk off nack", nack, 1'b0);
    ack_chk_en = 1;
    pulse(7);  check("R5 nack set", nack, 1'b1);
    pulse(12); check("R5 ack clears nack", nack, 1'b0);

    // R6 R7 R8 slave window
    do_reset(); mode = 2'b01;
    pulse(5); check("R6 match sets", flag, 1'b1);
    clear_flag(); check("R10 clear after read", flag, 1'b0);
    pulse(9); check("R7 rx in window", flag, 1'b1);
    clear_flag();
    pulse(8); check("R7 tx in window", flag, 1'b1);
    clear_flag();
    pulse(1); check("R8 stop sets", flag, 1'b1);
    clear_flag();
    pulse(8); check("R7 tx after stop", flag, 1'b0);
    pulse(6); clear_flag();
    pulse(0); check("R7 start no set", flag, 1'b0);
    pulse(9); check("R7 rx after restart", flag, 1'b0);

    // R10 clear protocol
    do_reset(); mode = 2'b00;
    write_flag(1'b1); check("R10 write1 no set", flag, 1'b0);
    pulse(3);
    write_flag(1'b0); check("R10 blind write0", flag, 1'b1);
    read_flag(v); check("R10 read value", v, 1'b1);
    write_flag(1'b1); write_flag(1'b0);
    check("R10 write disarms", flag, 1'b1);
    read_flag(v); write_flag(1'b0);
    check("R10 armed clear", flag, 1'b0);

    // R11 set beats clear in same cycle
    pulse(3); read_flag(v);
    @(negedge clk);
    wr_en = 1; wr_data = 0; clk9_rise = 1;
    @(negedge clk);
    wr_en = 0; clk9_rise = 0;
    check("R11 set wins", flag, 1'b1);

    // R12 enable gating
    irq_en = 0; #1 check("R12 disabled", irq, 1'b0);
    irq_en = 1; #1 check("R12 enabled", irq, 1'b1);

    // R1 reset clears flag and arm state
    read_flag(v); do_reset();
    check("R1 reset flag", flag, 1'b0);
    pulse(3); write_flag(1'b0);
    check("R1 reset disarms", flag, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule